// File: doc/BRIEF.md
# Quadrature Position Decoder with Cascade Outputs

This block turns the two phase-shifted channels of an incremental shaft encoder into a signed motion count. Every legal Gray-code step on the pair (one channel changes, the other holds) moves a 16-bit position register up or down by one. A-leading-B steps count up and B-leading-A steps count down. The block therefore counts four times per encoder cycle.

For systems that need more range than 16 bits, the block also drives three cascade signals meant for an external counter. The first is a direction level. The second is a one-clock pulse per decoded step. The third is a one-clock carry/borrow pulse whenever the position register wraps. The direction level is registered one clock before the matching pulse, so it is settled at the pulse's rising edge.

The channel inputs are expected to be synchronized to the clock already. For the cascade guarantee to hold, steps should be at least two clocks apart. The internal count is correct at any step rate.

Top module: `quad_cascade_decoder`

## Requirements
- R1: A channel pair sequence with A leading B, {a,b} = 00→10→11→01→00, adds one to the position for each single-channel change.
- R2: The reverse sequence, {a,b} = 00→01→11→10→00, subtracts one from the position for each single-channel change.
- R3: A sample in which both channels differ from the previous sample is illegal. It leaves the position unchanged, produces no step or carry pulse, and leaves the direction level as it was.
- R4: A legal change sampled at clock edge E1 raises the step pulse at edge E2 and drops it at edge E3. The position output shows the new value from E2 onward.
- R5: The direction level (1 = up, 0 = down) takes the step's direction at edge E1, one clock before the step pulse rises, and holds through the pulse.
- R6: An up step taken from position 16'hFFFF gives position 0 and raises the carry pulse for exactly the same clock as the step pulse.
- R7: A down step taken from position 0 gives position 16'hFFFF and raises the carry pulse for exactly the same clock as the step pulse.
- R8: While the active-low asynchronous reset is low, the position is 0, both pulses are 0 and the direction level is 0.
- R9: The first clock after reset release only records the channel levels as the reference. Whatever the channels hold at release causes no count.
- R10: Channels that stay constant cause no count and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_a | input | 1 | Encoder channel A, already synchronized |
| chan_b | input | 1 | Encoder channel B, already synchronized |
| position | output | 16 | Up/down position count |
| dir_up | output | 1 | Direction level: 1 counting up, 0 counting down |
| step_pulse | output | 1 | One-clock pulse per decoded step |
| wrap_pulse | output | 1 | One-clock carry/borrow pulse on wrap |

## Verification
A channel change driven before edge E1 produces results at three points:
- The direction level is due after E1, while the step pulse is still low and the position still holds its old value.
- The step pulse, the new position and any carry are due after E2.
- Both pulses must be low again after E3.

The bench drives each channel change on a falling edge and samples on the three falling edges that follow, one for each of these points. It waits three clocks between steps so that no result overlaps the next stimulus. Reset and priming checks sample only after several idle clocks, so any stray count would already be visible.

// File: rtl/quad_cascade_pkg.sv
package quad_cascade_pkg;

    // Step classification produced by the phase stage.
    typedef enum logic [1:0] {
        STEP_NONE    = 2'd0,
        STEP_UP      = 2'd1,
        STEP_DOWN    = 2'd2,
        STEP_ILLEGAL = 2'd3
    } step_kind_e;

    // Registered state of the phase stage.
    typedef struct packed {
        logic [1:0] ref_ab;   // previous channel sample {a,b}
        logic       primed;   // reference captured since reset
        logic       event_v;  // a legal step was decoded last clock
        logic       dir;      // direction of the latest legal step
    } phase_state_t;

    // Classify a transition between two channel samples {a,b}.
    function automatic step_kind_e classify(input logic [1:0] prev_ab,
                                            input logic [1:0] cur_ab);
        logic [1:0] diff;
        diff = prev_ab ^ cur_ab;
        if (diff == 2'b00)      return STEP_NONE;
        else if (diff == 2'b11) return STEP_ILLEGAL;
        // Up when new A differs from old B (A leads B).
        else if ((cur_ab[1] ^ prev_ab[0]) == 1'b1) return STEP_UP;
        else                    return STEP_DOWN;
    endfunction

endpackage

// File: rtl/quad_phase_stage.sv
module quad_phase_stage
    import quad_cascade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic event_o,
    output logic dir_o
);

    phase_state_t st_d, st_q;
    step_kind_e   kind;

    always_comb begin
        st_d         = st_q;
        kind         = classify(st_q.ref_ab, {a_i, b_i});
        st_d.ref_ab  = {a_i, b_i};
        st_d.primed  = 1'b1;
        st_d.event_v = 1'b0;
        if (st_q.primed) begin
            if (kind == STEP_UP) begin
                st_d.event_v = 1'b1;
                st_d.dir     = 1'b1;
            end else if (kind == STEP_DOWN) begin
                st_d.event_v = 1'b1;
                st_d.dir     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_o = st_q.event_v;
    assign dir_o   = st_q.dir;

    // An event needs exactly one channel to have changed against a primed reference.
    assert_single_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.event_v |-> ($past(st_q.primed) && $countones(st_q.ref_ab ^ $past(st_q.ref_ab)) == 1));

    // No event in the clock that captures the first reference.
    assert_prime_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.primed)) |-> !st_q.event_v);

    // Direction only moves when a legal step is decoded.
    assert_dir_moves_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.event_v |-> $stable(st_q.dir));

endmodule

// File: rtl/quad_count_stage.sv
module quad_count_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] count_o,
    output logic             step_o,
    output logic             wrap_o
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             step;
        logic             wrap;
        logic             last_up;
    } count_state_t;

    count_state_t cs_d, cs_q;

    always_comb begin
        cs_d      = cs_q;
        cs_d.step = 1'b0;
        cs_d.wrap = 1'b0;
        if (event_i) begin
            cs_d.step    = 1'b1;
            cs_d.last_up = up_i;
            if (up_i) begin
                cs_d.count = cs_q.count + ONE;
                cs_d.wrap  = (cs_q.count == TOP);
            end else begin
                cs_d.count = cs_q.count - ONE;
                cs_d.wrap  = (cs_q.count == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count_o = cs_q.count;
    assign step_o  = cs_q.step;
    assign wrap_o  = cs_q.wrap;

    // Count moves by exactly one per step, in the recorded direction.
    assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.step && cs_q.last_up) |-> cs_q.count == $past(cs_q.count) + ONE);
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.step && !cs_q.last_up) |-> cs_q.count == $past(cs_q.count) - ONE);

    // Without a step the count holds.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_q.step |-> $stable(cs_q.count));

    // Carry/borrow only accompanies a step pulse.
    assert_wrap_with_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.wrap |-> cs_q.step);

    // Overflow lands on zero, underflow on all ones.
    assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.wrap && cs_q.last_up) |-> cs_q.count == '0);
    assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.wrap && !cs_q.last_up) |-> cs_q.count == TOP);

endmodule

// File: rtl/quad_cascade_decoder.sv
module quad_cascade_decoder #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_a,
    input  logic             chan_b,
    output logic [WIDTH-1:0] position,
    output logic             dir_up,
    output logic             step_pulse,
    output logic             wrap_pulse
);

    logic evt;
    logic dir;

    quad_phase_stage u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (chan_a),
        .b_i     (chan_b),
        .event_o (evt),
        .dir_o   (dir)
    );

    quad_count_stage #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (evt),
        .up_i    (dir),
        .count_o (position),
        .step_o  (step_pulse),
        .wrap_o  (wrap_pulse)
    );

    assign dir_up = dir;

    // Every step pulse follows a decoded event one clock earlier.
    assert_pulse_follows_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(evt));

    // Unless a newer step arrived, direction did not move when the pulse rose.
    assert_dir_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !evt) |-> $stable(dir_up));

endmodule

// File: tb/tb_quad_cascade_decoder.sv
module tb_quad_cascade_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_a = 1'b0;
    logic        chan_b = 1'b0;
    logic [15:0] position;
    logic        dir_up;
    logic        step_pulse;
    logic        wrap_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    // Model state, computed from the requirements.
    logic [15:0] m_pos = 16'h0000;
    logic        m_dir = 1'b0;

    always #5 clk = ~clk;

    quad_cascade_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_a     (chan_a),
        .chan_b     (chan_b),
        .position   (position),
        .dir_up     (dir_up),
        .step_pulse (step_pulse),
        .wrap_pulse (wrap_pulse)
    );

    // Entry: {a, b, kind}; kind 01 = up, 10 = down, 00 = no count.
    localparam int NV = 14;
    localparam logic [3:0] VEC [NV] = '{
        4'b10_01, 4'b11_01, 4'b01_01, 4'b00_01,   // R1 up cycle
        4'b01_10, 4'b11_10, 4'b10_10, 4'b00_10,   // R2 down cycle
        4'b01_10,                                 // R7 0 -> FFFF
        4'b00_01,                                 // R6 FFFF -> 0
        4'b11_00,                                 // R3 double jump
        4'b11_00,                                 // R10 no change
        4'b10_10,                                 // R7 underflow again
        4'b11_01                                  // R6 overflow again
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        chk("R8 position in reset", position, 0);
        chk("R8 step in reset", step_pulse, 0);
        chk("R8 wrap in reset", wrap_pulse, 0);
        chk("R8 dir in reset", dir_up, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 idle position", position, 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] kind;
            logic       exp_wrap;
            kind     = VEC[i][1:0];
            exp_wrap = 1'b0;
            chan_a   = VEC[i][3];
            chan_b   = VEC[i][2];
            if (kind == 2'b01) begin
                exp_wrap = (m_pos == 16'hFFFF);
                m_dir    = 1'b1;
            end else if (kind == 2'b10) begin
                exp_wrap = (m_pos == 16'h0000);
                m_dir    = 1'b0;
            end
            @(negedge clk);  // after E1
            chk("R5 dir before pulse", dir_up, m_dir);
            chk("R4 no pulse at E1", step_pulse, 0);
            @(negedge clk);  // after E2
            if (kind == 2'b01) m_pos = m_pos + 16'd1;
            if (kind == 2'b10) m_pos = m_pos - 16'd1;
            chk(kind == 2'b00 ? "R3 position held" : (kind == 2'b01 ? "R1 position" : "R2 position"),
                position, m_pos);
            chk(kind == 2'b00 ? "R3 no step pulse" : "R4 step pulse", step_pulse, kind != 2'b00);
            chk(m_dir ? "R6 wrap pulse" : "R7 wrap pulse", wrap_pulse, exp_wrap);
            chk("R5 dir held in pulse", dir_up, m_dir);
            @(negedge clk);  // after E3
            chk("R4 pulse one clock", step_pulse, 0);
            chk("R6 wrap one clock", wrap_pulse, 0);
        end

        // R8 asynchronous reset mid-run clears position and direction
        @(negedge clk);
        chk("R1 before reset", position, m_pos);
        #2 rst_n = 1'b0;
        #1;
        chk("R8 async position clear", position, 0);
        chk("R8 async dir clear", dir_up, 0);

        // R9 channels at 01 while in reset: release must not count
        chan_a = 1'b0;
        chan_b = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 no count on release", position, 0);
        chk("R9 dir untouched", dir_up, 0);

        // R9 with 11 at release, then a legal up step 11 -> 01
        rst_n = 1'b0;
        chan_a = 1'b1;
        chan_b = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no count with 11", position, 0);
        chan_a = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 count after prime", position, 1);
        chk("R5 dir up after prime", dir_up, 1);

        finish_run();
    end

endmodule